// File: doc/BRIEF.md
# Display Window Geometry Calculator

This block turns the raw timing range of a video output (a horizontal start and end counted in dot-clock units, a vertical start and end counted in lines) into the rectangle of the picture that is actually visible. It divides the horizontal range by a divider that depends on the dot-clock mode, aligns the results, optionally re-centers a picture that is slightly off-center, clamps the visible size to the nominal resolution, and trims a thin right-hand border. It also chooses the nominal vertical resolution, which depends on the PAL flag and on the resolution chosen the previous time, and scales everything for double-height modes.

The surrounding logic captures a set of range and mode values by pulsing `start` while the block is idle. The block then runs two bit-serial dividers in parallel. When the results are written to the output registers it raises `done` and `dims_chg` together for one cycle. The output registers keep their values until the next computation finishes. All offsets and sizes are two's-complement values of RW+2 bits. A negative offset is passed through unchanged and is not range-checked here.

Top module: `dispwin_geom`

## Requirements
- R1: After reset the outputs are x=0, w=256, hres=256, y=0, h=240, vres=240, and busy, done and dims_chg are low.
- R2: A start pulse sampled while busy is low captures all inputs and raises busy on that edge. After RW+4 further rising edges (16 at the default RW=12), the six outputs take their new values and done and dims_chg are high for exactly one cycle, while busy is low again.
- R3: A start pulse while busy is high is ignored, and input changes after capture have no effect. The outputs change only on the edge that raises done.
- R4: The 3-bit mode selects the nominal width and the divider: code 0 gives 256/10, 2 gives 320/8, 4 gives 512/5, 6 gives 640/4, and every odd code gives 368/7.
- R5: When h_end > h_beg, the raw offset is (h_beg − B)/divider truncated toward zero, where B is 656 with PAL and 608 without, then rounded up to even with (x+1)&~1.
- R6: When h_end > h_beg, the raw width is (h_end − h_beg)/divider, adjusted by (w+2)&~3. When h_end ≤ h_beg, x and w are both 0 and no centering is done.
- R7: Centering code 2 replaces x with man_x. Codes 1 and 3 keep x. With code 0, c=((hres−w)/2)&~3 replaces x when 0 ≤ c ≤ 8 and |x| < 24.
- R8: If x+w > hres then w becomes hres−x. With centering code 0, hres is reduced by 4 when x ≤ 4 and hres−(x+w) ≥ 4; this also applies when the range is empty.
- R9: Vertically, y = v_beg − (PAL ? 39 : 16) and h = v_end − v_beg. vres is 256 when PAL is set and either h > 240 or the previous vres output is 256; otherwise vres is 240. When h ≤ 0, y and h pass through with no centering and no clamp.
- R10: With dbl set, y, h, vres and the centering tolerance (16) are all doubled before centering and clamping.
- R11: When h > 0, code 2 replaces y with man_y, and code 0 sets y to 0 when 0 ≤ vres−h ≤ 1 and |y| ≤ tolerance. Then, if y+h > vres, h becomes vres−y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a computation (taken only when idle) |
| h_beg | input | RW | Horizontal range start, dot clocks |
| h_end | input | RW | Horizontal range end, dot clocks |
| v_beg | input | VRW | Vertical range start, lines |
| v_end | input | VRW | Vertical range end, lines |
| mode | input | 3 | Dot-clock mode index |
| pal | input | 1 | PAL timing flag |
| dbl | input | 1 | Double-height flag |
| ctr | input | 2 | Centering code: 0 auto, 1 keep, 2 manual, 3 keep |
| man_x | input | RW+2 | Manual horizontal offset, signed |
| man_y | input | RW+2 | Manual vertical offset, signed |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| dims_chg | output | 1 | One-cycle strobe: dimensions updated |
| out_x | output | RW+2 | Horizontal offset, signed |
| out_w | output | RW+2 | Visible width, signed |
| out_hres | output | RW+2 | Horizontal resolution |
| out_y | output | RW+2 | Vertical offset, signed |
| out_h | output | RW+2 | Visible height, signed |
| out_vres | output | RW+2 | Vertical resolution |

## Verification
The bench builds the block with its defaults, RW=12 and VRW=10. This gives a 14-bit signed datapath and a completion latency of 16 edges. The 12-bit horizontal range lets an end value of 4095 produce a width far beyond every nominal resolution, which exercises the width clamp. It also lets starts below the 608/656 base produce negative offsets, which exercises truncation toward zero. The 10-bit vertical range reaches heights above 240 under PAL and, with double height, the 480 and 512 line resolutions.

// File: rtl/geom_pkg.sv
package geom_pkg;

  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_LOAD = 2'd1,
    GS_DIV  = 2'd2
  } geom_state_e;

  localparam int RST_HRES = 256;
  localparam int RST_VRES = 240;

  function automatic logic [9:0] hres_of(input logic [2:0] m);
    logic [9:0] r;
    if (m[0]) r = 10'd368;
    else begin
      case (m[2:1])
        2'd0:    r = 10'd256;
        2'd1:    r = 10'd320;
        2'd2:    r = 10'd512;
        default: r = 10'd640;
      endcase
    end
    return r;
  endfunction

  function automatic logic [3:0] div_of(input logic [2:0] m);
    logic [3:0] r;
    if (m[0]) r = 4'd7;
    else begin
      case (m[2:1])
        2'd0:    r = 4'd10;
        2'd1:    r = 4'd8;
        2'd2:    r = 4'd5;
        default: r = 4'd4;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/geom_div.sv
module geom_div #(
  parameter int NW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [3:0]    den,
  output logic [NW-1:0] quo,
  output logic          rdy
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] q_q, q_d;
  logic [3:0]    r_q, r_d;
  logic [CW-1:0] c_q, c_d;
  logic [4:0]    trial;

  always_comb begin
    trial = {r_q, q_q[NW-1]};
    q_d   = q_q;
    r_d   = r_q;
    c_d   = c_q;
    if (go) begin
      q_d = num;
      r_d = '0;
      c_d = CW'(NW);
    end else if (c_q != '0) begin
      if (trial >= {1'b0, den}) begin
        r_d = 4'(trial - {1'b0, den});
        q_d = {q_q[NW-2:0], 1'b1};
      end else begin
        r_d = trial[3:0];
        q_d = {q_q[NW-2:0], 1'b0};
      end
      c_d = c_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
      r_q <= '0;
      c_q <= '0;
    end else begin
      q_q <= q_d;
      r_q <= r_d;
      c_q <= c_d;
    end
  end

  assign quo = q_q;
  assign rdy = (c_q == '0);

endmodule

// File: rtl/geom_hcalc.sv
module geom_hcalc #(
  parameter int SW = 14
) (
  input  logic [SW-1:0] qx,
  input  logic          xneg,
  input  logic [SW-1:0] qw,
  input  logic          wpos,
  input  logic [SW-1:0] hbase,
  input  logic [1:0]    ctr,
  input  logic [SW-1:0] man_x,
  output logic [SW-1:0] x_o,
  output logic [SW-1:0] w_o,
  output logic [SW-1:0] hres_o
);
  typedef logic signed [SW-1:0] sv_t;

  sv_t xr, xe, wa, hr, cand, ax, xs, ws;

  always_comb begin
    xr   = xneg ? -sv_t'(qx) : sv_t'(qx);
    xe   = (xr + sv_t'(1)) & ~sv_t'(1);
    wa   = (sv_t'(qw) + sv_t'(2)) & ~sv_t'(3);
    hr   = sv_t'(hbase);
    cand = ((hr - wa) >>> 1) & ~sv_t'(3);
    ax   = xe[SW-1] ? -xe : xe;
    xs   = '0;
    ws   = '0;
    if (wpos) begin
      if (ctr == 2'd2)
        xs = sv_t'(man_x);
      else if (ctr == 2'd0 && !cand[SW-1] && cand <= sv_t'(8) && ax < sv_t'(24))
        xs = cand;
      else
        xs = xe;
      ws = (xs + wa > hr) ? hr - xs : wa;
    end
    if (ctr == 2'd0 && xs <= sv_t'(4) && hr - (xs + ws) >= sv_t'(4))
      hres_o = hr - sv_t'(4);
    else
      hres_o = hr;
    x_o = xs;
    w_o = ws;
  end

endmodule

// File: rtl/geom_vcalc.sv
module geom_vcalc #(
  parameter int VRW = 10,
  parameter int SW  = 14
) (
  input  logic [VRW-1:0] vb,
  input  logic [VRW-1:0] ve,
  input  logic           pal,
  input  logic           dbl,
  input  logic [1:0]     ctr,
  input  logic [SW-1:0]  man_y,
  input  logic [SW-1:0]  prev_vres,
  output logic [SW-1:0]  y_o,
  output logic [SW-1:0]  h_o,
  output logic [SW-1:0]  vres_o
);
  typedef logic signed [SW-1:0] sv_t;

  sv_t yb, hb, vr, tol, ys, hs, ay, gap;

  always_comb begin
    yb  = sv_t'(vb) - (pal ? sv_t'(39) : sv_t'(16));
    hb  = sv_t'(ve) - sv_t'(vb);
    vr  = (pal && (hb > sv_t'(240) || prev_vres == SW'(256))) ? sv_t'(256) : sv_t'(240);
    tol = sv_t'(16);
    if (dbl) begin
      yb  = yb <<< 1;
      hb  = hb <<< 1;
      vr  = vr <<< 1;
      tol = tol <<< 1;
    end
    ay  = yb[SW-1] ? -yb : yb;
    gap = vr - hb;
    ys  = yb;
    hs  = hb;
    if (hb > sv_t'(0)) begin
      if (ctr == 2'd2)
        ys = sv_t'(man_y);
      else if (ctr == 2'd0 && !gap[SW-1] && gap <= sv_t'(1) && ay <= tol)
        ys = '0;
      if (ys + hb > vr) hs = vr - ys;
    end
    y_o    = ys;
    h_o    = hs;
    vres_o = vr;
  end

endmodule

// File: rtl/dispwin_geom.sv
module dispwin_geom
  import geom_pkg::*;
#(
  parameter int RW  = 12,
  parameter int VRW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [RW-1:0]   h_beg,
  input  logic [RW-1:0]   h_end,
  input  logic [VRW-1:0]  v_beg,
  input  logic [VRW-1:0]  v_end,
  input  logic [2:0]      mode,
  input  logic            pal,
  input  logic            dbl,
  input  logic [1:0]      ctr,
  input  logic [RW+1:0]   man_x,
  input  logic [RW+1:0]   man_y,
  output logic            busy,
  output logic            done,
  output logic            dims_chg,
  output logic [RW+1:0]   out_x,
  output logic [RW+1:0]   out_w,
  output logic [RW+1:0]   out_hres,
  output logic [RW+1:0]   out_y,
  output logic [RW+1:0]   out_h,
  output logic [RW+1:0]   out_vres
);
  localparam int SW = RW + 2;
  localparam logic [SW-1:0] BASE_NTSC = SW'(608);
  localparam logic [SW-1:0] BASE_PAL  = SW'(656);

  logic [1:0] rs_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  geom_state_e st_q, st_d;
  logic cap_en, div_go, fin, rdy_x, rdy_w;

  logic [RW-1:0]  hb_q, he_q;
  logic [VRW-1:0] vb_q, ve_q;
  logic [2:0]     mode_q;
  logic           pal_q, dbl_q;
  logic [1:0]     ctr_q;
  logic [SW-1:0]  mx_q, my_q;

  assign cap_en = (st_q == GS_IDLE) && start;
  assign div_go = (st_q == GS_LOAD);
  assign fin    = (st_q == GS_DIV) && rdy_x && rdy_w;

  always_comb begin
    st_d = st_q;
    case (st_q)
      GS_IDLE: if (start) st_d = GS_LOAD;
      GS_LOAD: st_d = GS_DIV;
      GS_DIV:  if (rdy_x && rdy_w) st_d = GS_IDLE;
      default: st_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) st_q <= GS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      hb_q <= '0; he_q <= '0; vb_q <= '0; ve_q <= '0;
      mode_q <= '0; pal_q <= 1'b0; dbl_q <= 1'b0; ctr_q <= '0;
      mx_q <= '0; my_q <= '0;
    end else if (cap_en) begin
      hb_q <= h_beg; he_q <= h_end; vb_q <= v_beg; ve_q <= v_end;
      mode_q <= mode; pal_q <= pal; dbl_q <= dbl; ctr_q <= ctr;
      mx_q <= man_x; my_q <= man_y;
    end
  end

  // dot-clock operands for the two dividers
  logic signed [SW-1:0] xd, wd, xmag;
  logic [3:0]           den;
  logic [SW-1:0]        qx, qw, hbase;
  logic                 wpos;

  always_comb begin
    xd    = $signed({2'b00, hb_q}) - $signed(pal_q ? BASE_PAL : BASE_NTSC);
    wd    = $signed({2'b00, he_q}) - $signed({2'b00, hb_q});
    xmag  = xd[SW-1] ? -xd : xd;
    wpos  = !wd[SW-1] && (wd != '0);
    den   = div_of(mode_q);
    hbase = SW'(hres_of(mode_q));
  end

  geom_div #(.NW(SW)) u_divx (
    .clk(clk), .rst_n(rst_l), .go(div_go), .num(xmag), .den(den), .quo(qx), .rdy(rdy_x)
  );

  geom_div #(.NW(SW)) u_divw (
    .clk(clk), .rst_n(rst_l), .go(div_go), .num(wd), .den(den), .quo(qw), .rdy(rdy_w)
  );

  logic [SW-1:0] nx, nw, nhres, ny, nh, nvres;

  geom_hcalc #(.SW(SW)) u_h (
    .qx(qx), .xneg(xd[SW-1]), .qw(qw), .wpos(wpos), .hbase(hbase), .ctr(ctr_q),
    .man_x(mx_q), .x_o(nx), .w_o(nw), .hres_o(nhres)
  );

  geom_vcalc #(.VRW(VRW), .SW(SW)) u_v (
    .vb(vb_q), .ve(ve_q), .pal(pal_q), .dbl(dbl_q), .ctr(ctr_q), .man_y(my_q),
    .prev_vres(out_vres), .y_o(ny), .h_o(nh), .vres_o(nvres)
  );

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      out_x    <= '0;
      out_w    <= SW'(RST_HRES);
      out_hres <= SW'(RST_HRES);
      out_y    <= '0;
      out_h    <= SW'(RST_VRES);
      out_vres <= SW'(RST_VRES);
    end else if (fin) begin
      out_x    <= nx;
      out_w    <= nw;
      out_hres <= nhres;
      out_y    <= ny;
      out_h    <= nh;
      out_vres <= nvres;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      done     <= 1'b0;
      dims_chg <= 1'b0;
    end else begin
      done     <= fin;
      dims_chg <= fin;
    end
  end

  assign busy = (st_q != GS_IDLE);

endmodule

// File: rtl/geom_chk.sv
module geom_chk #(
  parameter int RW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [RW+1:0] out_x,
  input logic [RW+1:0] out_w,
  input logic [RW+1:0] out_hres,
  input logic [RW+1:0] out_y,
  input logic [RW+1:0] out_h,
  input logic [RW+1:0] out_vres
);
  localparam int SW = RW + 2;
  typedef logic signed [SW:0] ext_t;

  ext_t sx, sw, shr, sy, sh, svr;
  assign sx  = ext_t'($signed(out_x));
  assign sw  = ext_t'($signed(out_w));
  assign shr = ext_t'($signed(out_hres));
  assign sy  = ext_t'($signed(out_y));
  assign sh  = ext_t'($signed(out_h));
  assign svr = ext_t'($signed(out_vres));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_outputs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({out_x, out_w, out_hres, out_y, out_h, out_vres}));

  assert_hres_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_hres == SW'(256) || out_hres == SW'(252) || out_hres == SW'(320) ||
              out_hres == SW'(316) || out_hres == SW'(368) || out_hres == SW'(364) ||
              out_hres == SW'(512) || out_hres == SW'(508) || out_hres == SW'(640) ||
              out_hres == SW'(636)));

  assert_width_fits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sx + sw <= shr));

  assert_vres_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_vres == SW'(240) || out_vres == SW'(256) ||
              out_vres == SW'(480) || out_vres == SW'(512)));

  assert_height_fits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sh > 0) |-> (sy + sh <= svr));

endmodule

bind dispwin_geom geom_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_l), .start(start), .busy(busy), .done(done),
  .out_x(out_x), .out_w(out_w), .out_hres(out_hres),
  .out_y(out_y), .out_h(out_h), .out_vres(out_vres)
);

// File: tb/dispwin_geom_test.sv
`timescale 1ns/1ps
module dispwin_geom_test;
  localparam int RW  = 12;
  localparam int VRW = 10;
  localparam int SW  = RW + 2;
  localparam int LAT = SW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [RW-1:0] h_beg = '0, h_end = '0;
  logic [VRW-1:0] v_beg = '0, v_end = '0;
  logic [2:0] mode = '0;
  logic pal = 1'b0, dbl = 1'b0;
  logic [1:0] ctr = '0;
  logic [SW-1:0] man_x = '0, man_y = '0;
  logic busy, done, dims_chg;
  logic [SW-1:0] out_x, out_w, out_hres, out_y, out_h, out_vres;

  always #5 clk = ~clk;

  dispwin_geom #(.RW(RW), .VRW(VRW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .h_beg(h_beg), .h_end(h_end),
    .v_beg(v_beg), .v_end(v_end), .mode(mode), .pal(pal), .dbl(dbl), .ctr(ctr),
    .man_x(man_x), .man_y(man_y), .busy(busy), .done(done), .dims_chg(dims_chg),
    .out_x(out_x), .out_w(out_w), .out_hres(out_hres), .out_y(out_y), .out_h(out_h),
    .out_vres(out_vres)
  );

  int total = 0, bad = 0;
  bit chk_on = 0, finished = 0;
  string cur_tag = "R1";

  // reference model state
  int e_busy = 0, e_cnt = 0, e_done = 0;
  int e_x = 0, e_w = 256, e_hr = 256, e_y = 0, e_h = 240, e_vr = 240;
  int p_x, p_w, p_hr, p_y, p_h, p_vr;

  function automatic int absv(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic model(input int hb, he, vb, ve, md, pl, db, ct, mx, my, pv,
                       output int ox, ow, ohr, oy, oh, ovr);
    int hr, dv, x, w, c, y, sh, vr, tol;
    case (md)
      0: begin hr = 256; dv = 10; end
      2: begin hr = 320; dv = 8; end
      4: begin hr = 512; dv = 5; end
      6: begin hr = 640; dv = 4; end
      default: begin hr = 368; dv = 7; end
    endcase
    x = 0; w = 0;
    if (he - hb > 0) begin
      x = (hb - (pl ? 656 : 608)) / dv;
      x = (x + 1) & ~1;
      w = (he - hb) / dv;
      w = (w + 2) & ~3;
      if (ct == 2) x = mx;
      else if (ct == 0) begin
        c = ((hr - w) / 2) & ~3;
        if (c >= 0 && c <= 8 && absv(x) < 24) x = c;
      end
      if (x + w > hr) w = hr - x;
    end
    if (ct == 0 && x <= 4 && hr - (x + w) >= 4) hr = hr - 4;
    ox = x; ow = w; ohr = hr;
    y = vb - (pl ? 39 : 16);
    sh = ve - vb;
    vr = (pl && (sh > 240 || pv == 256)) ? 256 : 240;
    tol = 16;
    if (db) begin y = y * 2; sh = sh * 2; vr = vr * 2; tol = tol * 2; end
    if (sh > 0) begin
      if (ct == 2) y = my;
      else if (ct == 0 && vr - sh >= 0 && vr - sh <= 1 && absv(y) <= tol) y = 0;
      if (y + sh > vr) sh = vr - y;
    end
    oy = y; oh = sh; ovr = vr;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_busy = 0; e_cnt = 0; e_done = 0;
      e_x = 0; e_w = 256; e_hr = 256; e_y = 0; e_h = 240; e_vr = 240;
    end else if (e_busy != 0) begin
      if (e_cnt == 1) begin
        e_x = p_x; e_w = p_w; e_hr = p_hr; e_y = p_y; e_h = p_h; e_vr = p_vr;
        e_done = 1; e_busy = 0;
      end else begin
        e_cnt = e_cnt - 1; e_done = 0;
      end
    end else begin
      e_done = 0;
      if (start) begin
        model(int'(h_beg), int'(h_end), int'(v_beg), int'(v_end), int'(mode), int'(pal),
              int'(dbl), int'(ctr), int'($signed(man_x)), int'($signed(man_y)), e_vr,
              p_x, p_w, p_hr, p_y, p_h, p_vr);
        e_busy = 1; e_cnt = LAT;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !finished) begin
      chk(int'(busy), e_busy, "R2", "busy");
      chk(int'(done), e_done, "R2", "done");
      chk(int'(dims_chg), e_done, "R2", "dims_chg");
      chk(int'($signed(out_x)), e_x, cur_tag, "x");
      chk(int'($signed(out_w)), e_w, cur_tag, "w");
      chk(int'($signed(out_hres)), e_hr, cur_tag, "hres");
      chk(int'($signed(out_y)), e_y, cur_tag, "y");
      chk(int'($signed(out_h)), e_h, cur_tag, "h");
      chk(int'($signed(out_vres)), e_vr, cur_tag, "vres");
    end
  end

  task automatic set_in(input int hb, he, vb, ve, md, pl, db, ct, mx, my);
    h_beg = RW'(hb); h_end = RW'(he); v_beg = VRW'(vb); v_end = VRW'(ve);
    mode = 3'(md); pal = pl[0]; dbl = db[0]; ctr = 2'(ct);
    man_x = SW'(mx); man_y = SW'(my);
  endtask

  task automatic run(input string tag, input int hb, he, vb, ve, md, pl, db, ct, mx, my);
    @(negedge clk);
    cur_tag = tag;
    set_in(hb, he, vb, ve, md, pl, db, ct, mx, my);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1;
    // R1: reset values
    @(negedge clk);
    chk(int'($signed(out_w)), 256, "R1", "reset w");
    chk(int'($signed(out_hres)), 256, "R1", "reset hres");
    chk(int'($signed(out_h)), 240, "R1", "reset h");
    chk(int'($signed(out_vres)), 240, "R1", "reset vres");
    chk(int'(busy), 0, "R1", "reset busy");
    // R4: every mode code with a full-range window
    for (int m = 0; m < 8; m++) run("R4", 608, 3168, 16, 256, m, 0, 0, 1, 0, 0);
    // R5: offsets below and above the base, both standards
    run("R5", 600, 3000, 39, 295, 1, 1, 0, 1, 0, 0);
    run("R5", 100, 2000, 16, 200, 0, 0, 0, 1, 0, 0);
    run("R5", 700, 2700, 20, 220, 2, 0, 0, 1, 0, 0);
    run("R5", 661, 2661, 50, 250, 4, 1, 0, 1, 0, 0);
    // R6: empty or reversed horizontal range
    run("R6", 2000, 2000, 16, 256, 0, 0, 0, 1, 0, 0);
    run("R6", 2500, 1000, 16, 256, 6, 0, 0, 0, 0, 0);
    run("R6", 608, 2100, 16, 256, 3, 0, 0, 1, 0, 0);
    // R7: centering codes
    run("R7", 620, 3180, 16, 256, 0, 0, 0, 0, 0, 0);
    run("R7", 620, 3180, 16, 256, 0, 0, 0, 2, -6, 0);
    run("R7", 620, 3180, 16, 256, 0, 0, 0, 3, 0, 0);
    run("R7", 900, 3000, 16, 256, 2, 0, 0, 0, 0, 0);
    // R8: clamp and border trim
    run("R8", 100, 4095, 16, 256, 6, 0, 0, 1, 0, 0);
    run("R8", 608, 2608, 16, 256, 0, 0, 0, 0, 0, 0);
    run("R8", 608, 4095, 16, 256, 4, 0, 0, 0, 0, 0);
    // R9: vertical resolution selection and its memory
    run("R9", 608, 3168, 39, 327, 0, 1, 0, 1, 0, 0);
    run("R9", 608, 3168, 50, 200, 0, 1, 0, 1, 0, 0);
    run("R9", 608, 3168, 50, 200, 0, 0, 0, 1, 0, 0);
    run("R9", 608, 3168, 300, 100, 0, 0, 0, 0, 0, 0);
    // R10: double height
    run("R10", 608, 3168, 16, 256, 0, 0, 1, 0, 0, 0);
    run("R10", 608, 3168, 60, 330, 0, 1, 1, 1, 0, 0);
    // R11: vertical centering and clamp
    run("R11", 608, 3168, 20, 260, 0, 0, 0, 0, 0, 0);
    run("R11", 608, 3168, 40, 279, 0, 0, 0, 0, 0, 0);
    run("R11", 608, 3168, 20, 260, 0, 0, 0, 2, 0, 10);
    run("R11", 608, 3168, 100, 400, 0, 0, 0, 1, 0, 0);
    // R3: a second start and input changes while busy are ignored
    @(negedge clk);
    cur_tag = "R3";
    set_in(650, 3000, 30, 250, 2, 0, 0, 1, 0, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    set_in(100, 4000, 5, 500, 5, 1, 1, 2, 44, 33);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(int'($signed(out_hres)), 320, "R3", "hres from first capture");
    @(negedge clk);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule